// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block keeps the sixteen visible 32-bit general registers of a multi-mode processor core. Each processor mode works on a shared set of low registers. It also has private copies of the stack and link registers, r13 and r14. The fast-interrupt mode keeps private copies of r8 through r14. When the core loads a new mode, the block parks the outgoing mode's banked registers in storage and brings in the incoming mode's copies within one clock.

Read and write ports each carry a target mode. An access aimed at the bank currently in use touches the live registers. An access aimed at any other bank reaches that bank's parked copy directly, without a mode change. The block also holds the current status word and one saved-status word for each bank that has one. A privilege output reports whether the current mode is privileged.

Top module: `banked_regfile`

## Requirements
- R1: After reset the mode is 19 (supervisor), the privilege output is 1, every live and parked register reads 0, and every status word reads 0 apart from the mode bits of the current status.
- R2: A 5-bit mode picks a bank through a fixed table: 0 and 16 select user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined, 31 system, and every other value selects a dummy bank. A mode loaded with the strobe shows on `curMode` one clock later. `privOut` is 1 exactly when bits [1:0] of the current mode are not both zero.
- R3: A change between two banks, neither of them fast-interrupt or dummy, exchanges only r13 and r14. r0 to r12 and r15 keep their values.
- R4: On entry to the fast-interrupt bank, the live r8 to r12 are kept as the user copies, and r8 to r14 load from the fast-interrupt copies. On leaving it, r8 to r12 reload from the user copies, and the fast-interrupt r8 to r14 are kept.
- R5: Entering the dummy bank makes r8 to r14 read 0. Reads that target a dummy mode from another bank return 0, and writes that target it are dropped.
- R6: A mode load that keeps the same bank (for example 16 to 0) moves no register.
- R7: Register access is resolved by bank. If the target mode maps to the current bank, the live register is used. Otherwise r13 and r14 use the target bank's parked copy. r8 to r12 use the fast-interrupt copy when that bank is the target, or the user copy when the fast-interrupt bank is current. r0 to r7 and r15 are always live.
- R8: Reads are combinational. A read in the cycle of a mode load returns pre-load values. A write in the same cycle as a mode load is applied before the exchange, so its value ends up in the correct bank.
- R9: The saved-status read of a mode whose bank has no saved word (user, system, dummy) returns the current status word.
- R10: A saved-status write whose target bank has no saved word is dropped. A write to one bank's saved word leaves every other bank's word unchanged.
- R11: The status word has four byte fields selected by `stFieldEn`: bit 3 flags [31:24], bit 2 status [23:16], bit 1 extension [15:8], bit 0 control [7:0]. In user modes only the flags field is written.
- R12: Bits [4:0] of `curStatus` always show the current mode. A control-field write stores only bits [7:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeIn | input | 5 | Mode to load |
| modeLoad | input | 1 | Strobe: load `modeIn` as the current mode |
| curMode | output | 5 | Current mode |
| privOut | output | 1 | Current mode is privileged |
| rdMode | input | 5 | Target mode of the register read |
| rdAddr | input | 4 | Register number to read |
| rdData | output | 32 | Read data (combinational) |
| wrEn | input | 1 | Register write enable |
| wrMode | input | 5 | Target mode of the register write |
| wrAddr | input | 4 | Register number to write |
| wrData | input | 32 | Register write data |
| stWrEn | input | 1 | Current status write enable |
| stFieldEn | input | 4 | Field enables for the status write |
| stWrData | input | 32 | Status write data |
| curStatus | output | 32 | Current status word, mode in bits [4:0] |
| ssRdMode | input | 5 | Mode whose saved status is read |
| ssRdData | output | 32 | Saved-status read data (combinational) |
| ssWrEn | input | 1 | Saved-status write enable |
| ssWrMode | input | 5 | Mode whose saved status is written |
| ssWrData | input | 32 | Saved-status write data |

## Verification
Register reads and saved-status reads have no latency. The bench sets the address and mode and samples a moment later in the same low clock phase. Mode loads, register writes and status writes take effect at the next rising edge. The bench drives them on a falling edge, lets exactly one rising edge pass, and checks on the following falling edge. For R8, the bench checks the read during the low phase in which the load strobe is high, before the edge that applies it.

// File: rtl/bank_pkg.sv
package bank_pkg;

  localparam int MODE_W    = 5;
  localparam int ADDR_W    = 4;
  localparam int NUM_REGS  = 16;
  localparam int NUM_BANKS = 8;
  localparam int HI_LO     = 8;   // first register private to the fast-interrupt bank
  localparam int HI_N      = 5;   // r8..r12
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_NONE
  } bank_e;

  typedef enum logic [2:0] {
    SL_LIVE, SL_USRHI, SL_FIQHI, SL_BANK, SL_ZERO
  } slot_e;

  typedef struct packed {
    logic  swapEn;
    bank_e oldBank;
    bank_e newBank;
    logic  wrGo;
    slot_e wrSlot;
    bank_e wrBank;
    slot_e rdSlot;
    bank_e rdBank;
    logic  userOnly;
    logic  ssRdOwn;
    bank_e ssRdBank;
    logic  ssWrGo;
    bank_e ssWrBank;
  } ctrl_t;

  function automatic bank_e modeToBank(input logic [MODE_W-1:0] m);
    case (m)
      5'd0,  5'd16: modeToBank = BK_USR;
      5'd1,  5'd17: modeToBank = BK_FIQ;
      5'd2,  5'd18: modeToBank = BK_IRQ;
      5'd3,  5'd19: modeToBank = BK_SVC;
      5'd23:        modeToBank = BK_ABT;
      5'd27:        modeToBank = BK_UND;
      5'd31:        modeToBank = BK_SYS;
      default:      modeToBank = BK_NONE;
    endcase
  endfunction

  function automatic logic hasSaved(input bank_e b);
    hasSaved = (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
               (b == BK_ABT) || (b == BK_UND);
  endfunction

  // Where an access to register a of bank tgt lands while bank cur is live.
  function automatic slot_e pickSlot(input bank_e cur, input bank_e tgt,
                                     input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(HI_LO) || a == 4'd15 || tgt == cur) pickSlot = SL_LIVE;
    else if (tgt == BK_NONE)                          pickSlot = SL_ZERO;
    else if (a >= ADDR_W'(SP_IDX))                    pickSlot = SL_BANK;
    else if (tgt == BK_FIQ)                           pickSlot = SL_FIQHI;
    else if (cur == BK_FIQ)                           pickSlot = SL_USRHI;
    else                                              pickSlot = SL_LIVE;
  endfunction

endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] rdMode,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [MODE_W-1:0] ssRdMode,
  input  logic              ssWrEn,
  input  logic [MODE_W-1:0] ssWrMode,
  output logic [MODE_W-1:0] curMode,
  output logic              privOut,
  output ctrl_t             st
);

  bank_e curBank, nextBank, rdBank, wrBank, ssRdBank, ssWrBank;

  always_ff @(posedge clk) begin
    if (!rstN)         curMode <= RESET_MODE;
    else if (modeLoad) curMode <= modeIn;
  end

  always_comb begin
    curBank  = modeToBank(curMode);
    nextBank = modeToBank(modeIn);
    rdBank   = modeToBank(rdMode);
    wrBank   = modeToBank(wrMode);
    ssRdBank = modeToBank(ssRdMode);
    ssWrBank = modeToBank(ssWrMode);
  end

  assign privOut = |curMode[1:0];

  always_comb begin
    st.swapEn   = modeLoad && (curBank != nextBank);
    st.oldBank  = curBank;
    st.newBank  = nextBank;
    st.wrSlot   = pickSlot(curBank, wrBank, wrAddr);
    st.wrGo     = wrEn && (st.wrSlot != SL_ZERO);
    st.wrBank   = wrBank;
    st.rdSlot   = pickSlot(curBank, rdBank, rdAddr);
    st.rdBank   = rdBank;
    st.userOnly = (curBank == BK_USR);
    st.ssRdOwn  = hasSaved(ssRdBank);
    st.ssRdBank = ssRdBank;
    st.ssWrGo   = ssWrEn && hasSaved(ssWrBank);
    st.ssWrBank = ssWrBank;
  end

  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rstN)
    modeLoad |=> curMode == $past(modeIn));

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !modeLoad |=> $stable(curMode));

endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             st,
  input  logic [MODE_W-1:0] curMode,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stWrEn,
  input  logic [3:0]        stFieldEn,
  input  logic [DATA_W-1:0] stWrData,
  output logic [DATA_W-1:0] curStatus,
  output logic [DATA_W-1:0] ssRdData,
  input  logic [DATA_W-1:0] ssWrData
);

  localparam int FIELD_W = DATA_W / 4;

  logic [NUM_REGS-1:0][DATA_W-1:0]  live,  liveN;
  logic [HI_N-1:0][DATA_W-1:0]      usrHi, usrHiN;
  logic [HI_N-1:0][DATA_W-1:0]      fiqHi, fiqHiN;
  logic [NUM_BANKS-1:0][DATA_W-1:0] spBank, spBankN;
  logic [NUM_BANKS-1:0][DATA_W-1:0] lrBank, lrBankN;
  logic [DATA_W-1:0]                savedStat [NUM_BANKS];
  logic [DATA_W-1:MODE_W]           statReg;
  logic                             unusedLowBits;

  assign unusedLowBits = ^stWrData[MODE_W-1:0];

  // Next state: the port write first, then the bank exchange on top of it.
  always_comb begin
    liveN   = live;
    usrHiN  = usrHi;
    fiqHiN  = fiqHi;
    spBankN = spBank;
    lrBankN = lrBank;

    if (st.wrGo) begin
      case (st.wrSlot)
        SL_LIVE:  liveN[wrAddr] = wrData;
        SL_USRHI: usrHiN[wrAddr[2:0]] = wrData;
        SL_FIQHI: fiqHiN[wrAddr[2:0]] = wrData;
        SL_BANK: begin
          if (wrAddr == ADDR_W'(SP_IDX)) spBankN[st.wrBank] = wrData;
          else                           lrBankN[st.wrBank] = wrData;
        end
        default: ;
      endcase
    end

    if (st.swapEn) begin
      // park the outgoing bank
      if (st.oldBank == BK_FIQ) begin
        for (int i = 0; i < HI_N; i++) fiqHiN[i] = liveN[HI_LO+i];
        spBankN[BK_FIQ] = liveN[SP_IDX];
        lrBankN[BK_FIQ] = liveN[LR_IDX];
      end else if (st.oldBank != BK_NONE) begin
        if (st.newBank == BK_FIQ)
          for (int i = 0; i < HI_N; i++) usrHiN[i] = liveN[HI_LO+i];
        spBankN[st.oldBank] = liveN[SP_IDX];
        lrBankN[st.oldBank] = liveN[LR_IDX];
      end
      // bring in the incoming bank
      if (st.newBank == BK_FIQ) begin
        for (int i = 0; i < HI_N; i++) liveN[HI_LO+i] = fiqHiN[i];
        liveN[SP_IDX] = spBankN[BK_FIQ];
        liveN[LR_IDX] = lrBankN[BK_FIQ];
      end else if (st.newBank == BK_NONE) begin
        for (int i = HI_LO; i <= LR_IDX; i++) liveN[i] = '0;
      end else begin
        if (st.oldBank == BK_FIQ)
          for (int i = 0; i < HI_N; i++) liveN[HI_LO+i] = usrHiN[i];
        liveN[SP_IDX] = spBankN[st.newBank];
        liveN[LR_IDX] = lrBankN[st.newBank];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      live   <= '0;
      usrHi  <= '0;
      fiqHi  <= '0;
      spBank <= '0;
      lrBank <= '0;
    end else begin
      live   <= liveN;
      usrHi  <= usrHiN;
      fiqHi  <= fiqHiN;
      spBank <= spBankN;
      lrBank <= lrBankN;
    end
  end

  always_comb begin
    case (st.rdSlot)
      SL_LIVE:  rdData = live[rdAddr];
      SL_USRHI: rdData = usrHi[rdAddr[2:0]];
      SL_FIQHI: rdData = fiqHi[rdAddr[2:0]];
      SL_BANK:  rdData = (rdAddr == ADDR_W'(SP_IDX)) ? spBank[st.rdBank]
                                                     : lrBank[st.rdBank];
      default:  rdData = '0;
    endcase
  end

  // Current status: four byte fields, mode bits come from the mode register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
    end else if (stWrEn) begin
      if (stFieldEn[3])
        statReg[DATA_W-1:3*FIELD_W] <= stWrData[DATA_W-1:3*FIELD_W];
      if (!st.userOnly) begin
        if (stFieldEn[2])
          statReg[3*FIELD_W-1:2*FIELD_W] <= stWrData[3*FIELD_W-1:2*FIELD_W];
        if (stFieldEn[1])
          statReg[2*FIELD_W-1:FIELD_W] <= stWrData[2*FIELD_W-1:FIELD_W];
        if (stFieldEn[0])
          statReg[FIELD_W-1:MODE_W] <= stWrData[FIELD_W-1:MODE_W];
      end
    end
  end

  assign curStatus = {statReg, curMode};

  // Saved status words exist only for banks that own one.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_saved
    if (hasSaved(bank_e'(b))) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)
          savedStat[b] <= '0;
        else if (st.ssWrGo && st.ssWrBank == bank_e'(b))
          savedStat[b] <= ssWrData;
      end
    end else begin : g_none
      assign savedStat[b] = '0;
    end
  end

  assign ssRdData = st.ssRdOwn ? savedStat[st.ssRdBank] : curStatus;

  a_r6_no_move: assert property (@(posedge clk) disable iff (!rstN)
    (!st.swapEn && !(st.wrGo && st.wrSlot == SL_LIVE)) |=> $stable(live));

  a_r3_low_kept: assert property (@(posedge clk) disable iff (!rstN)
    (st.swapEn && !(st.wrGo && st.wrSlot == SL_LIVE)) |=>
      (live[0] == $past(live[0]) && live[7] == $past(live[7]) &&
       live[15] == $past(live[15])));

  a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rstN)
    (st.swapEn && st.newBank == BK_NONE) |=>
      (live[HI_LO] == '0 && live[SP_IDX] == '0 && live[LR_IDX] == '0));

  a_r8_write_before_swap: assert property (@(posedge clk) disable iff (!rstN)
    (st.swapEn && st.wrGo && st.wrSlot == SL_BANK && st.wrBank == st.newBank &&
     wrAddr == ADDR_W'(SP_IDX)) |=> live[SP_IDX] == $past(wrData));

  a_r11_user_flags: assert property (@(posedge clk) disable iff (!rstN)
    (stWrEn && st.userOnly) |=> $stable(statReg[3*FIELD_W-1:MODE_W]));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        modeIn,
  input  logic              modeLoad,
  output logic [4:0]        curMode,
  output logic              privOut,
  input  logic [4:0]        rdMode,
  input  logic [3:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [4:0]        wrMode,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stWrEn,
  input  logic [3:0]        stFieldEn,
  input  logic [DATA_W-1:0] stWrData,
  output logic [DATA_W-1:0] curStatus,
  input  logic [4:0]        ssRdMode,
  output logic [DATA_W-1:0] ssRdData,
  input  logic              ssWrEn,
  input  logic [4:0]        ssWrMode,
  input  logic [DATA_W-1:0] ssWrData
);

  ctrl_t strobes;

  bank_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeIn   (modeIn),
    .modeLoad (modeLoad),
    .rdMode   (rdMode),
    .rdAddr   (rdAddr),
    .wrEn     (wrEn),
    .wrMode   (wrMode),
    .wrAddr   (wrAddr),
    .ssRdMode (ssRdMode),
    .ssWrEn   (ssWrEn),
    .ssWrMode (ssWrMode),
    .curMode  (curMode),
    .privOut  (privOut),
    .st       (strobes)
  );

  bank_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .curMode   (curMode),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .stWrEn    (stWrEn),
    .stFieldEn (stFieldEn),
    .stWrData  (stWrData),
    .curStatus (curStatus),
    .ssRdData  (ssRdData),
    .ssWrData  (ssWrData)
  );

endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  modeIn = '0;
  logic        modeLoad = 1'b0;
  logic [4:0]  curMode;
  logic        privOut;
  logic [4:0]  rdMode = '0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        wrEn = 1'b0;
  logic [4:0]  wrMode = '0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        stWrEn = 1'b0;
  logic [3:0]  stFieldEn = '0;
  logic [31:0] stWrData = '0;
  logic [31:0] curStatus;
  logic [4:0]  ssRdMode = '0;
  logic [31:0] ssRdData;
  logic        ssWrEn = 1'b0;
  logic [4:0]  ssWrMode = '0;
  logic [31:0] ssWrData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeLoad(modeLoad),
    .curMode(curMode), .privOut(privOut), .rdMode(rdMode), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(wrEn), .wrMode(wrMode), .wrAddr(wrAddr),
    .wrData(wrData), .stWrEn(stWrEn), .stFieldEn(stFieldEn),
    .stWrData(stWrData), .curStatus(curStatus), .ssRdMode(ssRdMode),
    .ssRdData(ssRdData), .ssWrEn(ssWrEn), .ssWrMode(ssWrMode),
    .ssWrData(ssWrData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkReg(input string req, input int m, input int a, input logic [31:0] exp);
    rdMode = 5'(m);
    rdAddr = 4'(a);
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic chkSs(input string req, input int m, input logic [31:0] exp);
    ssRdMode = 5'(m);
    #1;
    chk(req, ssRdData, exp);
  endtask

  task automatic wr(input int m, input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrMode = 5'(m); wrAddr = 4'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic switchTo(input int m);
    @(negedge clk);
    modeLoad = 1'b1; modeIn = 5'(m);
    @(negedge clk);
    modeLoad = 1'b0;
  endtask

  task automatic stWrite(input logic [3:0] en, input logic [31:0] d);
    @(negedge clk);
    stWrEn = 1'b1; stFieldEn = en; stWrData = d;
    @(negedge clk);
    stWrEn = 1'b0;
  endtask

  task automatic ssWrite(input int m, input logic [31:0] d);
    @(negedge clk);
    ssWrEn = 1'b1; ssWrMode = 5'(m); ssWrData = d;
    @(negedge clk);
    ssWrEn = 1'b0;
  endtask

  // Representative mode of the bank a mode value selects (R2 table), -1 for dummy.
  function automatic int repOf(input int m);
    if (m >= 16 && m <= 19) return m;
    if (m < 4) return m + 16;
    if (m == 23 || m == 27 || m == 31) return m;
    return -1;
  endfunction

  function automatic logic [31:0] spTag(input int m);
    int r = repOf(m);
    return (r < 0) ? 32'h0 : (32'h1300_0000 | 32'(r));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    chk("R1 mode", 32'(curMode), 32'd19);
    chk("R1 priv", 32'(privOut), 32'd1);
    chk("R1 status", curStatus, 32'h13);
    for (int a = 0; a < 16; a++) chkReg("R1 live reg", 19, a, 32'h0);
    chkReg("R1 parked fiq r8", 17, 8, 32'h0);
    chkReg("R1 parked irq r13", 18, 13, 32'h0);
    chkSs("R1 saved irq", 18, 32'h0);

    // R7/R2: exhaustive target-mode write then read from supervisor
    wr(19, 0, 32'hC0DE_0000);
    for (int m = 0; m < 32; m++) wr(m, 13, 32'h1300_0000 | 32'(m));
    for (int m = 0; m < 32; m++) chkReg("R7 R2 target r13 by bank", m, 13, spTag(m));

    // R2/R3/R5: walk every mode value
    for (int m = 0; m < 32; m++) begin
      switchTo(m);
      chk("R2 curMode", 32'(curMode), 32'(m));
      chk("R2 privOut", 32'(privOut), 32'((m & 3) != 0));
      chkReg("R3 R5 live r13 after load", m, 13, spTag(m));
      chkReg("R3 r0 kept", m, 0, 32'hC0DE_0000);
    end

    // R4: fast-interrupt banking
    switchTo(16);
    for (int i = 8; i < 15; i++) wr(16, i, 32'h0800_0000 | 32'(i));
    for (int i = 8; i < 15; i++) wr(17, i, 32'h0F00_0000 | 32'(i));
    chkReg("R7 fiq copy from user", 17, 8, 32'h0F00_0008);
    chkReg("R7 user live", 16, 8, 32'h0800_0008);
    @(negedge clk);
    modeLoad = 1'b1; modeIn = 5'd17;
    chkReg("R8 read during load is old", 16, 8, 32'h0800_0008);
    @(negedge clk);
    modeLoad = 1'b0;
    for (int i = 8; i < 15; i++) chkReg("R4 fiq live", 17, i, 32'h0F00_0000 | 32'(i));
    for (int i = 8; i < 13; i++) chkReg("R4 user copy", 16, i, 32'h0800_0000 | 32'(i));
    chkReg("R4 user r13 parked", 16, 13, 32'h0800_000D);
    chkReg("R3 r0 in fiq", 17, 0, 32'hC0DE_0000);
    wr(17, 9, 32'h0000_0F99);
    switchTo(18);
    for (int i = 8; i < 13; i++) chkReg("R4 leave fiq restores", 18, i, 32'h0800_0000 | 32'(i));
    chkReg("R4 irq r13", 18, 13, 32'h1300_0012);
    chkReg("R7 fiq parked r9", 17, 9, 32'h0000_0F99);
    switchTo(17);
    chkReg("R4 fiq r9 kept", 17, 9, 32'h0000_0F99);
    chkReg("R4 fiq r13 kept", 17, 13, 32'h0F00_000D);

    // R6: same-bank mode change
    switchTo(16);
    switchTo(0);
    chkReg("R6 r13 unmoved", 0, 13, 32'h0800_000D);
    chkReg("R6 r8 unmoved", 0, 8, 32'h0800_0008);
    chk("R6 privOut", 32'(privOut), 32'd0);

    // R8: write in the load cycle lands before the exchange
    @(negedge clk);
    modeLoad = 1'b1; modeIn = 5'd19;
    wrEn = 1'b1; wrMode = 5'd0; wrAddr = 4'd13; wrData = 32'hAAAA_0013;
    @(negedge clk);
    modeLoad = 1'b0; wrEn = 1'b0;
    chkReg("R8 parked user r13", 16, 13, 32'hAAAA_0013);
    chkReg("R8 svc r13", 19, 13, 32'h1300_0013);

    // R5: dummy bank
    wr(5, 13, 32'h0000_5555);
    chkReg("R5 dummy write dropped", 5, 13, 32'h0);
    chkReg("R5 dummy read r9", 9, 9, 32'h0);
    switchTo(5);
    for (int i = 8; i < 15; i++) chkReg("R5 dummy live zero", 5, i, 32'h0);
    chkReg("R5 r0 kept", 5, 0, 32'hC0DE_0000);
    switchTo(19);
    chkReg("R5 svc r13 back", 19, 13, 32'h1300_0013);

    // R11/R12: current status fields
    stWrite(4'b1111, 32'hF1F2_F3E0);
    chk("R12 R11 all fields", curStatus, 32'hF1F2_F3F3);
    stWrite(4'b0100, 32'h00AA_0000);
    chk("R11 status field only", curStatus, 32'hF1AA_F3F3);
    stWrite(4'b0001, 32'h0000_0040);
    chk("R12 control bits 7:5", curStatus, 32'hF1AA_F353);

    // R9/R10: saved status
    ssWrite(17, 32'h1234_5678);
    chkSs("R10 fiq saved", 17, 32'h1234_5678);
    chkSs("R10 irq untouched", 18, 32'h0);
    ssWrite(16, 32'hDEAD_BEEF);
    chkSs("R9 R10 user falls back", 16, 32'hF1AA_F353);
    ssWrite(31, 32'hDEAD_BEEF);
    chkSs("R9 R10 system falls back", 31, 32'hF1AA_F353);
    chkSs("R9 dummy falls back", 9, 32'hF1AA_F353);
    ssWrite(23, 32'h0000_0BAD);
    chkSs("R10 abort saved", 23, 32'h0000_0BAD);
    chkSs("R10 fiq still", 1, 32'h1234_5678);

    // R11: user mode writes flags only
    switchTo(16);
    chk("R12 mode in status", curStatus, 32'hF1AA_F350);
    stWrite(4'b1111, 32'h0F00_FFFF);
    chk("R11 user flags only", curStatus, 32'h0FAA_F350);
    chkSs("R9 user reads own status", 0, 32'h0FAA_F350);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule